// File: doc/BRIEF.md
# Multi-channel ADC conversion sequencer

This block is the digital side of an eight-input analog-to-digital converter. Software uses a small register bus to set a control register and a power-up enable bit. It reads back a completion flag and four result registers. Toward the analog part, the block drives a channel select and a one-cycle start strobe. It then waits for a done pulse that carries an 8-bit unsigned code: 0x00 stands for the low reference and 0xFF for the high reference.

Every run is a sequence of four conversions, and each result goes into one of four result slots. There are two ways to fill the slots. In the first, one selected channel is converted four times in a row. In the second, a group of four adjacent channels is converted once each, in ascending order. A sequence runs either once after each control write or over and over until the next write. A control write in the middle of a sequence drops the conversion in progress and starts again from the first slot with the new settings.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every readable address (0 to 5) returns 0x00, and `conv_start` is low.
- R2: A read of address 0 returns bit7 = completion flag, bit6 = 0, bit5 = SCAN, bit4 = MULT, bit3 = CD, bit2 = CC, bit1 = CB, bit0 = CA. A write to bit 7 or bit 6 has no effect.
- R3: Bit 7 of address 5 is the power-up enable, and it reads back in bit 7. While it is 0, no `conv_start` is issued. A pending request starts once it is set to 1.
- R4: With MULT=0, channel CC:CB:CA is converted four times. The results go to addresses 1, 2, 3 and 4 in that order.
- R5: With MULT=1, CC picks channels 0-3 (CC=0) or 4-7 (CC=1), and CB and CA are ignored. The results for the four channels, in ascending channel order, go to addresses 1 to 4.
- R6: With SCAN=0, exactly one four-conversion sequence runs after each control write, and the block then stays idle.
- R7: With SCAN=1, sequences repeat without a break and overwrite addresses 1-4 in place. The completion flag stays set.
- R8: The completion flag sets when the fourth result of a sequence is stored. It clears on any write to address 0.
- R9: A control write during a sequence drops the conversion in flight. It restarts the sequence at the first slot with the new settings.
- R10: Addresses 1-4 are read-only, and bus writes to them are ignored.
- R11: `conv_start` is a one-cycle pulse, issued only after the previous conversion's done. `conv_chan` is held stable between starts.
- R12: A done pulse that arrives while no conversion is outstanding does not change any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address (0 control, 1-4 results, 5 option) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| conv_start | output | 1 | One-cycle conversion start |
| conv_chan | output | 3 | Channel to convert |
| conv_done | input | 1 | Conversion finished, `conv_code` valid |
| conv_code | input | 8 | Conversion result |

## Verification
A slot counter that is off by one puts a code into the wrong result address. This shows at the next read of addresses 1-4. A wrong channel derivation shows on `conv_chan` in the same cycle as the start pulse. The bench's reference model compares these, together with the read data, on every clock. So a divergence is reported within one cycle of the edge that caused it. A wrong sequencer state shows as an extra, missing or early start pulse, or as a completion flag that does not match the model at the next read of address 0. The explicit checks also decode the channel field that the converter model embeds in each code. This ties every stored result to the channel that produced it.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the ADC conversion sequencer.
// Assumes an 8-bit register bus with control at address 0 and the
// result slots starting at address 1.
package adc_seq_pkg;
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_RES0 = 1;

    // Control register bit positions (software-visible layout).
    localparam int CTL_FLAG = 7;
    localparam int CTL_SCAN = 5;
    localparam int CTL_MULT = 4;
    localparam int OPT_PWR  = 7;

    // Stored control fields; sel holds CD:CC:CB:CA.
    typedef struct packed {
        logic       scan;
        logic       mult;
        logic [3:0] sel;
    } seq_cfg_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_t;
endpackage

// File: rtl/adc_seq_regs.sv
`timescale 1ns/1ps
// Control and option register storage.
// Decodes bus writes and produces a one-cycle control-write strike.
// Assumes DATA_W >= 8 so that the fixed control layout fits.
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int SLOTS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              ctrl_wr,
    output seq_cfg_t          cfg,
    output logic              power
);
    localparam int ADDR_OPT = ADDR_RES0 + SLOTS;

    logic opt_wr;
    logic unused_wdata;

    assign ctrl_wr      = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
    assign opt_wr       = bus_wr && (bus_addr == ADDR_W'(ADDR_OPT));
    assign unused_wdata = ^bus_wdata[DATA_W-1:6];

    // Capture mode and channel fields on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (ctrl_wr) begin
            cfg.scan <= bus_wdata[CTL_SCAN];
            cfg.mult <= bus_wdata[CTL_MULT];
            cfg.sel  <= bus_wdata[3:0];
        end
    end

    // Capture the power-up enable on an option write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            power <= 1'b0;
        end else if (opt_wr) begin
            power <= bus_wdata[OPT_PWR];
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
// Conversion sequencer. It issues four conversions per sequence, picks
// the channel of each one, steers results into slots and raises the
// completion flag. A control write aborts the sequence and restarts it.
// Assumes the converter answers each start with exactly one done pulse.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int CHAN_W = 3,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              scan,
    input  logic              mult,
    input  logic [CHAN_W-1:0] chan_sel,
    input  logic              power,
    input  logic              conv_done,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic              res_we,
    output logic [SLOT_W-1:0] res_slot,
    output logic              ccf
);
    localparam int GRP_W = CHAN_W - SLOT_W;
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    seq_state_t        state;
    logic              run;
    logic [CHAN_W-1:0] next_chan;

    // Channel for the current slot: the group base plus the slot, or a fixed channel.
    always_comb begin
        if (mult) begin
            next_chan = {chan_sel[CHAN_W-1:SLOT_W], res_slot};
        end else begin
            next_chan = chan_sel;
        end
    end

    assign res_we = (state == SEQ_WAIT) && conv_done && !ctrl_wr;

    // Sequence control: restart on write, start when idle, advance on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_IDLE;
            run        <= 1'b0;
            res_slot   <= '0;
            ccf        <= 1'b0;
            conv_start <= 1'b0;
            conv_chan  <= '0;
        end else begin
            conv_start <= 1'b0;
            if (ctrl_wr) begin
                state    <= SEQ_IDLE;
                run      <= 1'b1;
                res_slot <= '0;
                ccf      <= 1'b0;
            end else begin
                case (state)
                    SEQ_IDLE: begin
                        if (run && power) begin
                            conv_start <= 1'b1;
                            conv_chan  <= next_chan;
                            state      <= SEQ_WAIT;
                        end
                    end
                    SEQ_WAIT: begin
                        if (conv_done) begin
                            state <= SEQ_IDLE;
                            if (res_slot == LAST) begin
                                res_slot <= '0;
                                ccf      <= 1'b1;
                                run      <= scan;
                            end else begin
                                res_slot <= res_slot + 1'b1;
                            end
                        end
                    end
                    default: state <= SEQ_IDLE;
                endcase
            end
        end
    end

    // R11: the start strobe never lasts two cycles
    p_start_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R11: the channel only moves together with a start
    p_chan_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start |-> $stable(conv_chan));

    // R3: no start without the power-up enable in the cycle before
    p_start_powered_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(power));

    // R8: a control write always leaves the flag clear
    p_flag_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !ccf);

    // R8: storing the last slot raises the flag
    p_flag_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && res_slot == LAST) |=> ccf);

    // R4: a non-final store moves on to the next slot
    p_slot_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && res_slot != LAST) |=> (res_slot == $past(res_slot) + 1'b1));

    // R9: a control write returns the sequence to slot zero
    p_restart_slot0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (res_slot == '0));

    logic unused_grp;
    assign unused_grp = (GRP_W > 0);
endmodule

// File: rtl/adc_seq_results.sv
`timescale 1ns/1ps
// Bank of result slots, one register per slot, written only by the
// sequencer. There is no bus write path to these registers.
module adc_seq_results #(
    parameter int SLOTS  = 4,
    parameter int DATA_W = 8,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [SLOT_W-1:0]            slot,
    input  logic [DATA_W-1:0]            code,
    output logic [SLOTS-1:0][DATA_W-1:0] res_q
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Load this slot when the sequencer stores into it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q[g] <= '0;
            end else if (we && slot == SLOT_W'(g)) begin
                res_q[g] <= code;
            end
        end
    end

    // R10/R12: without a sequencer store, no slot changes
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(res_q));
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
// Top level of the ADC conversion sequencer: register storage,
// sequencer, result bank and the bus read multiplexer.
// Assumes bus reads are combinational in the address.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int SLOTS  = 4,
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_code
);
    localparam int SLOT_W   = $clog2(SLOTS);
    localparam int ADDR_OPT = ADDR_RES0 + SLOTS;

    logic                         ctrl_wr;
    seq_cfg_t                     cfg;
    logic                         power;
    logic                         res_we;
    logic [SLOT_W-1:0]            res_slot;
    logic                         ccf;
    logic [SLOTS-1:0][DATA_W-1:0] res_q;

    adc_seq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .ctrl_wr  (ctrl_wr),
        .cfg      (cfg),
        .power    (power)
    );

    adc_seq_fsm #(.SLOTS(SLOTS), .CHAN_W(CHAN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .scan      (cfg.scan),
        .mult      (cfg.mult),
        .chan_sel  (cfg.sel[CHAN_W-1:0]),
        .power     (power),
        .conv_done (conv_done),
        .conv_start(conv_start),
        .conv_chan (conv_chan),
        .res_we    (res_we),
        .res_slot  (res_slot),
        .ccf       (ccf)
    );

    adc_seq_results #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_res (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (res_we),
        .slot (res_slot),
        .code (conv_code),
        .res_q(res_q)
    );

    // Bus read multiplexer: control, option and result slots.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADDR_CTRL)) begin
            bus_rdata[CTL_FLAG] = ccf;
            bus_rdata[CTL_SCAN] = cfg.scan;
            bus_rdata[CTL_MULT] = cfg.mult;
            bus_rdata[3:0]      = cfg.sel;
        end else if (bus_addr == ADDR_W'(ADDR_OPT)) begin
            bus_rdata[OPT_PWR] = power;
        end
        for (int i = 0; i < SLOTS; i++) begin
            if (bus_addr == ADDR_W'(ADDR_RES0 + i)) begin
                bus_rdata = res_q[i];
            end
        end
    end

    // R2: bit 6 of the control read is always zero
    p_bit6_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(ADDR_CTRL)) |-> !bus_rdata[6]);
endmodule

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    wire  [7:0] bus_rdata;
    wire        conv_start;
    wire  [2:0] conv_chan;
    logic       done_r = 1'b0;
    logic       stray = 1'b0;
    logic [7:0] code_r = '0;
    wire        conv_done = done_r | stray;
    wire  [7:0] conv_code = stray ? 8'hEE : code_r;

    always #4 clk = ~clk;

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_done(conv_done), .conv_code(conv_code)
    );

    int    n_tests = 0;
    int    n_fail = 0;
    int    n_starts = 0;
    string cur_req = "R1";

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Converter model: fixed latency, code = {channel, running count}.
    logic [2:0] cch = '0;
    logic       busy = 1'b0;
    int         cnt = 0;
    int         nconv = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (conv_start) begin
                busy <= 1'b1;
                cnt  <= LAT;
                cch  <= conv_chan;
            end else if (busy) begin
                if (cnt == 1) begin
                    busy   <= 1'b0;
                    done_r <= 1'b1;
                    code_r <= {cch, 5'(nconv)};
                    nconv  <= nconv + 1;
                end else begin
                    cnt <= cnt - 1;
                end
            end
        end
    end

    always @(posedge clk) if (rst_n && conv_start) n_starts++;

    // Reference model built from the requirements.
    logic [7:0] m_cfg;
    logic       m_pwr, m_ccf, m_pend, m_wait, m_start;
    int         m_slot;
    logic [2:0] m_chan;
    logic [7:0] m_res [4];
    always @(posedge clk) begin
        logic st;
        st = 1'b0;
        if (!rst_n) begin
            m_cfg = '0; m_pwr = 0; m_ccf = 0; m_pend = 0; m_wait = 0;
            m_slot = 0; m_chan = '0;
            for (int i = 0; i < 4; i++) m_res[i] = '0;
        end else if (bus_wr && bus_addr == 3'd0) begin
            m_cfg = bus_wdata & 8'h3F; m_ccf = 0; m_pend = 1; m_wait = 0; m_slot = 0;
        end else begin
            if (m_wait && conv_done) begin
                m_res[m_slot] = conv_code;
                m_wait = 0;
                if (m_slot == 3) begin
                    m_slot = 0; m_ccf = 1;
                    if (!m_cfg[5]) m_pend = 0;
                end else begin
                    m_slot++;
                end
            end else if (!m_wait && m_pend && m_pwr) begin
                st = 1'b1;
                m_chan = m_cfg[4] ? {m_cfg[2], 2'(m_slot)} : m_cfg[2:0];
                m_wait = 1;
            end
            if (bus_wr && bus_addr == 3'd5) m_pwr = bus_wdata[7];
        end
        m_start = st;
    end

    function automatic logic [7:0] model_rd(logic [2:0] a);
        if (a == 0) return {m_ccf, 1'b0, m_cfg[5:0]};
        if (a >= 1 && a <= 4) return m_res[a-1];
        if (a == 5) return {m_pwr, 7'b0};
        return 8'h00;
    endfunction

    // Cycle-by-cycle comparison, sampled away from the edge.
    always @(posedge clk) begin
        #3;
        if (rst_n) begin
            chk({cur_req, " start"}, conv_start, m_start);
            if (m_wait) chk({cur_req, " chan"}, conv_chan, m_chan);
            chk({cur_req, " rdata"}, bus_rdata, model_rd(bus_addr));
        end
    end

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] v);
        @(negedge clk); bus_addr = a;
        @(posedge clk); #3; v = bus_rdata;
    endtask

    task automatic wait_flag(string req);
        logic [7:0] v;
        for (int i = 0; i < 300; i++) begin
            rd(3'd0, v);
            if (v[7]) return;
        end
        chk({req, " flag timeout"}, 0, 1);
    endtask

    task automatic chk_chans(string req, logic [2:0] c0, logic [2:0] c1,
                             logic [2:0] c2, logic [2:0] c3);
        logic [7:0] v;
        rd(3'd1, v); chk({req, " slot1"}, v[7:5], c0);
        rd(3'd2, v); chk({req, " slot2"}, v[7:5], c1);
        rd(3'd3, v); chk({req, " slot3"}, v[7:5], c2);
        rd(3'd4, v); chk({req, " slot4"}, v[7:5], c3);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v, a, b;
        logic [7:0] keep [4];
        int s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        cur_req = "R1";
        for (int i = 0; i < 6; i++) begin
            rd(3'(i), v); chk("R1 reset read", v, 8'h00);
        end
        chk("R1 no start", n_starts, 0);

        // R3: power-up bit read-back
        cur_req = "R3";
        wr(3'd5, 8'h80);
        rd(3'd5, v); chk("R3 power readback", v, 8'h80);

        // R4/R8: single channel 5, four times
        cur_req = "R4";
        wr(3'd0, 8'h05);
        wait_flag("R8");
        rd(3'd0, v); chk("R8 flag set, R2 layout", v, 8'h85);
        chk_chans("R4", 3'd5, 3'd5, 3'd5, 3'd5);

        // R6: single shot stays idle
        cur_req = "R6";
        s = n_starts;
        repeat (30) @(negedge clk);
        chk("R6 no further starts", n_starts - s, 0);

        // R12: stray done while idle
        cur_req = "R12";
        for (int i = 0; i < 4; i++) rd(3'(i + 1), keep[i]);
        @(negedge clk); stray = 1'b1;
        @(negedge clk); stray = 1'b0;
        for (int i = 0; i < 4; i++) begin
            rd(3'(i + 1), v); chk("R12 slot unchanged", v, keep[i]);
        end

        // R10: result writes ignored
        cur_req = "R10";
        wr(3'd1, 8'h00);
        wr(3'd4, 8'hFF);
        rd(3'd1, v); chk("R10 slot1 read-only", v, keep[0]);
        rd(3'd4, v); chk("R10 slot4 read-only", v, keep[3]);

        // R5: group 1, CB/CA ignored
        cur_req = "R5";
        wr(3'd0, 8'h17);
        wait_flag("R5");
        chk_chans("R5", 3'd4, 3'd5, 3'd6, 3'd7);

        // R2: bits 7 and 6 not writable
        cur_req = "R2";
        wr(3'd0, 8'hC2);
        rd(3'd0, v); chk("R2 readback masks 7:6", v, 8'h02);
        wait_flag("R2");
        chk_chans("R2", 3'd2, 3'd2, 3'd2, 3'd2);

        // R7: continuous group 0
        cur_req = "R7";
        wr(3'd0, 8'h30);
        wait_flag("R7");
        rd(3'd1, a);
        repeat (60) @(negedge clk);
        rd(3'd1, b);
        chk("R7 overwritten in place", (a != b), 1);
        chk("R7 channel kept", b[7:5], 3'd0);
        rd(3'd0, v); chk("R7 flag stays set", v, 8'hB0);
        chk_chans("R7", 3'd0, 3'd1, 3'd2, 3'd3);

        // R9: abort and restart
        cur_req = "R9";
        wr(3'd0, 8'h07);
        s = n_starts;
        while (n_starts == s) @(negedge clk);
        repeat (2) @(negedge clk);
        s = n_starts;
        wr(3'd0, 8'h11);
        rd(3'd0, v); chk("R9 flag cleared by write", v, 8'h11);
        wait_flag("R9");
        chk("R9 four starts after restart", n_starts - s, 4);
        chk_chans("R9", 3'd0, 3'd1, 3'd2, 3'd3);

        // R3: gated by power, resumes when enabled
        cur_req = "R3";
        wr(3'd5, 8'h00);
        wr(3'd0, 8'h01);
        s = n_starts;
        repeat (30) @(negedge clk);
        chk("R3 no start unpowered", n_starts - s, 0);
        rd(3'd0, v); chk("R3 flag clear unpowered", v, 8'h01);
        wr(3'd5, 8'h80);
        wait_flag("R3");
        chk("R3 four starts once powered", n_starts - s, 4);
        chk_chans("R3", 3'd1, 3'd1, 3'd1, 3'd1);

        // R11: checked each cycle by the reference comparison
        cur_req = "R11";
        repeat (5) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule